// File: doc/BRIEF.md
# GPIO Interrupt Cause Controller

This block gives a bank of general-purpose pins (32 by default) a simple register interface and per-pin interrupt detection. Every pin has a direction bit, an output latch and an input-inversion bit. Each incoming line is first passed through a two-flop synchroniser. It is then XORed with its inversion bit. The result is the adjusted input, which software reads back and which drives both interrupt paths.

A pin raises a level interrupt while its adjusted input is high and its level enable is set. A pin raises an edge interrupt once a 0-to-1 step of its adjusted input has been caught in a sticky cause register and its edge enable is set. Because the inversion comes first, inversion 0 selects rising-edge or active-high sensing, and inversion 1 selects falling-edge or active-low sensing. The level and edge terms of each pin are merged and qualified by the direction bit. They are then OR-reduced over groups of eight pins into one summary line per group, which feeds the chip's main interrupt controller.

The register port is single-cycle. A write takes effect at the clock edge on which `bus_wr` is high. Read data is a combinational function of `bus_addr`.

Top module: `gpio_irq_cause_ctrl`

## Requirements
- R1: After reset, every writable register reads 0: direction (offset 0), output (1), inversion (3), edge cause (4), edge enable (5) and level enable (6). `irq_o` is 0.
- R2: A write to offset 0, 1, 3, 5 or 6 stores `bus_wdata`, and a read of the same offset returns it.
- R3: Offset 2 reads the adjusted input. Each bit is the synchronised pin XOR its inversion bit. A pin change is visible there two clock edges after it is sampled.
- R4: `pin_o` equals the output register, and `pin_oe` is the bitwise inverse of the direction register, where a direction bit of 1 means input.
- R5: Offset 7 reads, for each pin, the adjusted input when its direction bit is 1 and the output latch when it is 0.
- R6: A pin's level term is its adjusted input AND its level enable bit.
- R7: A 0-to-1 step of a pin's adjusted input sets its edge cause bit on the third clock edge after the pin changes. The bit stays set after the input returns. Its edge term is the cause bit AND its edge enable bit.
- R8: Writing offset 4 clears each cause bit whose data bit is 0 and keeps each bit whose data bit is 1. A new edge arriving at the same clock edge as a clear leaves the bit set.
- R9: Changing an inversion bit while the pin is steady never sets an edge cause bit.
- R10: `irq_o[g]` is the OR, over pins 8g to 8g+7, of (level term OR edge term) AND direction bit. A pin configured as output never contributes.
- R11: Writes to offsets 2 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 32 | Asynchronous pin inputs |
| pin_o | output | 32 | Output latch values |
| pin_oe | output | 32 | Output enables (1 = drive) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 4 | Per-group summary interrupts |

## Verification
The bench builds the block with its default parameters: 32 pins in four groups of eight. At that size a walk over every pin, in both inversion settings and in both the level and edge paths, is short enough to run in full. It therefore reaches every group boundary and every cause bit. It also covers the same-edge race between a clear and a new edge, an inversion flip on a steady pin, and output-configured pins masking their causes. Every expected summary line is computed in the bench from the pin, inversion and enable values it drove.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_OUT   = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_DIN   = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_INV   = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_CAUSE = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_EMASK = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_LMASK = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_VIEW  = 3'd7;

  // Adjusted input: synchronised value with optional inversion.
  function automatic logic [63:0] f_adjust(input logic [63:0] raw, input logic [63:0] inv);
    return raw ^ inv;
  endfunction

  // Rising step of the adjusted signal; both samples use the current inversion.
  function automatic logic [63:0] f_rise(input logic [63:0] cur, input logic [63:0] prev,
                                         input logic [63:0] inv);
    return (cur ^ inv) & ~(prev ^ inv);
  endfunction

  // Per-pin merged cause, qualified by direction.
  function automatic logic [63:0] f_cause(input logic [63:0] din, input logic [63:0] lmask,
                                          input logic [63:0] cause, input logic [63:0] emask,
                                          input logic [63:0] dir);
    return ((din & lmask) | (cause & emask)) & dir;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_edge_cause.sv
module gpio_edge_cause #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] event_i,
  input  logic             clr_wr_i,
  input  logic [WIDTH-1:0] clr_data_i,
  output logic [WIDTH-1:0] cause_o
);
  logic [WIDTH-1:0] cause_q;
  logic [WIDTH-1:0] keep_w;

  assign keep_w = clr_wr_i ? (cause_q & clr_data_i) : cause_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= keep_w | event_i;
  end

  assign cause_o = cause_q;

  // R7
  edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|event_i) |=> ((cause_o & $past(event_i)) == $past(event_i)));

  // R8
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_o & ~$past(cause_o) & ~$past(event_i)) == '0));

  // R8
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr_i && event_i == '0) |=> ((cause_o & ~$past(clr_data_i)) == '0));
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
  parameter int WIDTH   = 32,
  parameter int GROUP_W = 8,
  localparam int NGROUP = WIDTH / GROUP_W
) (
  input  logic [WIDTH-1:0]  pin_cause_i,
  output logic [NGROUP-1:0] irq_o
);
  for (genvar g = 0; g < NGROUP; g++) begin : g_grp
    assign irq_o[g] = |pin_cause_i[g*GROUP_W +: GROUP_W];
  end
endmodule

// File: rtl/gpio_irq_cause_ctrl.sv
module gpio_irq_cause_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int GROUP_W  = 8,
  localparam int NGROUP  = NUM_PINS / GROUP_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] bus_rdata,
  output logic [NGROUP-1:0]   irq_o
);
  logic [NUM_PINS-1:0] dir_q, out_q, inv_q, emask_q, lmask_q;
  logic [NUM_PINS-1:0] sync_w, prev_w, din_w, rise_w, cause_w, pin_cause_w;
  logic [63:0]         din_x, rise_x, pc_x;
  logic                cause_wr_w;

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pin_i), .sync_o(sync_w), .prev_o(prev_w)
  );

  assign din_x  = f_adjust(64'(sync_w), 64'(inv_q));
  assign rise_x = f_rise(64'(sync_w), 64'(prev_w), 64'(inv_q));
  assign din_w  = din_x[NUM_PINS-1:0];
  assign rise_w = rise_x[NUM_PINS-1:0];

  assign cause_wr_w = bus_wr && (bus_addr == OFS_CAUSE);

  gpio_edge_cause #(.WIDTH(NUM_PINS)) u_cause (
    .clk(clk), .rst_n(rst_n), .event_i(rise_w),
    .clr_wr_i(cause_wr_w), .clr_data_i(bus_wdata), .cause_o(cause_w)
  );

  assign pc_x = f_cause(64'(din_w), 64'(lmask_q), 64'(cause_w), 64'(emask_q), 64'(dir_q));
  assign pin_cause_w = pc_x[NUM_PINS-1:0];

  gpio_irq_group #(.WIDTH(NUM_PINS), .GROUP_W(GROUP_W)) u_group (
    .pin_cause_i(pin_cause_w), .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      inv_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_DIR:   dir_q   <= bus_wdata;
        OFS_OUT:   out_q   <= bus_wdata;
        OFS_INV:   inv_q   <= bus_wdata;
        OFS_EMASK: emask_q <= bus_wdata;
        OFS_LMASK: lmask_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_DIR:   bus_rdata = dir_q;
      OFS_OUT:   bus_rdata = out_q;
      OFS_DIN:   bus_rdata = din_w;
      OFS_INV:   bus_rdata = inv_q;
      OFS_CAUSE: bus_rdata = cause_w;
      OFS_EMASK: bus_rdata = emask_q;
      OFS_LMASK: bus_rdata = lmask_q;
      default:   bus_rdata = (din_w & dir_q) | (out_q & ~dir_q);
    endcase
  end

  assign pin_o  = out_q;
  assign pin_oe = ~dir_q;

  // R10
  quiet_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lmask_q == '0 && emask_q == '0) |-> (irq_o == '0));

  // R10
  outputs_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q == '0) |-> (irq_o == '0));

  // R9
  inv_flip_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_w == prev_w) |-> (rise_w == '0));

  // R11
  ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == OFS_DIN || bus_addr == OFS_VIEW)) |=>
      ($stable(dir_q) && $stable(out_q) && $stable(inv_q) && $stable(emask_q) && $stable(lmask_q)));
endmodule

// File: tb/gpio_irq_cause_ctrl_bench.sv
module gpio_irq_cause_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_i = '0;
  logic [31:0] pin_o, pin_oe, bus_rdata;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_irq_cause_ctrl u_gpio_irq_cause_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic logic [3:0] grp(input logic [31:0] v);
    logic [3:0] r;
    for (int g = 0; g < 4; g++) r[g] = (((v >> (8*g)) & 32'hFF) != 0);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bwrite(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, keep_rd;
    logic [31:0] pats [4];
    pats[0] = 32'h0000_0000; pats[1] = 32'hA5A5_0F0F;
    pats[2] = 32'h8000_0100; pats[3] = 32'hFFFF_FFFF;

    wait_cyc(3);
    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      if (a == 2) continue;
      bread(3'(a), rd); chk("R1 reset reg", rd, 32'h0);
    end
    chk("R1 reset irq", {28'h0, irq_o}, 32'h0);
    rst_n = 1'b1;
    wait_cyc(1);

    // R2 readback, R4 pins
    bwrite(3'd0, 32'h1234_5678); bwrite(3'd1, 32'hCAFE_F00D);
    bread(3'd0, rd); chk("R2 dir", rd, 32'h1234_5678);
    bread(3'd1, rd); chk("R2 out", rd, 32'hCAFE_F00D);
    chk("R4 pin_o", pin_o, 32'hCAFE_F00D);
    chk("R4 pin_oe", pin_oe, ~32'h1234_5678);
    bwrite(3'd5, 32'h0F0F_0F0F); bread(3'd5, rd); chk("R2 emask", rd, 32'h0F0F_0F0F);
    bwrite(3'd6, 32'hF0F0_F0F0); bread(3'd6, rd); chk("R2 lmask", rd, 32'hF0F0_F0F0);
    bwrite(3'd3, 32'h3333_CCCC); bread(3'd3, rd); chk("R2 inv", rd, 32'h3333_CCCC);

    // R5 mixed view and R3 adjusted input
    pin_i = 32'h5555_AAAA;
    wait_cyc(2);
    bread(3'd2, rd); chk("R3 din", rd, 32'h5555_AAAA ^ 32'h3333_CCCC);
    bread(3'd7, rd);
    chk("R5 view", rd, ((32'h5555_AAAA ^ 32'h3333_CCCC) & 32'h1234_5678) |
                       (32'hCAFE_F00D & ~32'h1234_5678));

    // R11 writes to read-only offsets
    bread(3'd2, keep_rd);
    bwrite(3'd2, 32'hDEAD_BEEF); bwrite(3'd7, 32'hDEAD_BEEF);
    bread(3'd2, rd); chk("R11 din", rd, keep_rd);
    bread(3'd0, rd); chk("R11 dir", rd, 32'h1234_5678);
    bread(3'd1, rd); chk("R11 out", rd, 32'hCAFE_F00D);
    bread(3'd3, rd); chk("R11 inv", rd, 32'h3333_CCCC);

    // R6/R10 level sweep: patterns crossed with inversions, all inputs
    bwrite(3'd0, 32'hFFFF_FFFF); bwrite(3'd5, 32'h0); bwrite(3'd6, 32'hFFFF_FFFF);
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        bwrite(3'd3, pats[j]);
        pin_i = pats[i];
        wait_cyc(3);
        bread(3'd2, rd); chk("R3 din sweep", rd, pats[i] ^ pats[j]);
        chk("R6 level irq", {28'h0, irq_o}, {28'h0, grp(pats[i] ^ pats[j])});
      end
    end
    // R6 walking single pin, single level enable
    bwrite(3'd3, 32'h0); pin_i = 32'h0; wait_cyc(3);
    for (int p = 0; p < 32; p++) begin
      bwrite(3'd6, 32'h1 << p);
      pin_i = 32'h1 << p; wait_cyc(3);
      chk("R6 walk hit", {28'h0, irq_o}, {28'h0, grp(32'h1 << p)});
      pin_i = ~(32'h1 << p); wait_cyc(3);
      chk("R6 walk miss", {28'h0, irq_o}, 32'h0);
    end
    // R10 output-configured pins never contribute
    bwrite(3'd6, 32'hFFFF_FFFF); pin_i = 32'hFFFF_FFFF; wait_cyc(3);
    bwrite(3'd0, 32'h00FF_00FF);
    chk("R10 dir gate", {28'h0, irq_o}, {28'h0, grp(32'h00FF_00FF)});
    bwrite(3'd0, 32'hFFFF_FFFF);

    // R7/R8 edge sweep: every pin, both inversions
    bwrite(3'd6, 32'h0); bwrite(3'd5, 32'hFFFF_FFFF);
    for (int pol = 0; pol < 2; pol++) begin
      for (int p = 0; p < 32; p++) begin
        bwrite(3'd3, pol ? 32'hFFFF_FFFF : 32'h0);
        pin_i = pol ? 32'hFFFF_FFFF : 32'h0;
        wait_cyc(3);
        bwrite(3'd4, 32'h0);
        pin_i = pin_i ^ (32'h1 << p);
        wait_cyc(3);
        bread(3'd4, rd); chk("R7 edge set", rd, 32'h1 << p);
        chk("R7 edge irq", {28'h0, irq_o}, {28'h0, grp(32'h1 << p)});
        pin_i = pin_i ^ (32'h1 << p);
        wait_cyc(3);
        bread(3'd4, rd); chk("R7 sticky", rd, 32'h1 << p);
        bwrite(3'd4, 32'hFFFF_FFFF);
        bread(3'd4, rd); chk("R8 write1 keeps", rd, 32'h1 << p);
        bwrite(3'd4, ~(32'h1 << p));
        bread(3'd4, rd); chk("R8 write0 clears", rd, 32'h0);
        chk("R8 irq cleared", {28'h0, irq_o}, 32'h0);
      end
    end
    // R7 edge enable gates the edge term
    bwrite(3'd3, 32'h0); pin_i = 32'h0; wait_cyc(3); bwrite(3'd4, 32'h0);
    bwrite(3'd5, 32'h0000_FF00);
    pin_i = 32'h0101_0101; wait_cyc(3);
    bread(3'd4, rd); chk("R7 multi set", rd, 32'h0101_0101);
    chk("R7 emask irq", {28'h0, irq_o}, 32'h2);

    // R8 clear racing a new edge on the same clock edge
    bwrite(3'd5, 32'hFFFF_FFFF);
    pin_i = 32'h0; wait_cyc(3); bwrite(3'd4, 32'h0);
    pin_i = 32'h0000_0010;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 32'h0;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
    bread(3'd4, rd); chk("R8 edge wins clear", rd, 32'h0000_0010);

    // R9 inversion flip on steady pins
    bwrite(3'd4, 32'h0);
    pin_i = 32'hFFFF_FFFF; wait_cyc(3); bwrite(3'd4, 32'h0);
    bwrite(3'd3, 32'hFFFF_FFFF); wait_cyc(2);
    bwrite(3'd3, 32'h0); wait_cyc(2);
    bread(3'd4, rd); chk("R9 no edge on flip", rd, 32'h0);
    chk("R9 irq quiet", {28'h0, irq_o}, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule